// File: doc/BRIEF.md
# Indexed Extended Configuration Register Port

This block is a bank of thirty-two 8-bit extended configuration registers reached through a two-address I/O window. The host first writes an 8-bit index to the window's index port (window address 0). It then performs exactly one read or write at the data port (window address 1). That single data access uses up the index, so every later data access needs its own fresh index write. The registers live at indexes A0h to BFh. Any other index selects nothing.

Some bits in the bank act as write-protect locks for register groups outside the block. The external groups are the palette, overscan, miscellaneous output, horizontal and vertical sync polarity, cursor start/end and vertical timing. For each group, the chip's address decoder raises a hit line, and the block returns a write enable that is the host write strobe masked by the group's lock. The block also drives a 2-bit video clock divider select and a 4-bit clock select code. The code is built from two bank bits and the two clock bits of the external miscellaneous output register.

The sequencer is a two-state machine with states XS_IDLE (no live index) and XS_ARMED (index live). Its transitions are:
- T_ARM, XS_IDLE to XS_ARMED, on an index write.
- T_REARM, XS_ARMED to XS_ARMED, on an index write that replaces the stored index.
- T_CONSUME, XS_ARMED to XS_IDLE, on any data access.
- T_IGNORE, XS_IDLE to XS_IDLE, on a data access, which is discarded.

Top module: `xreg_port`

## Requirements
- R1: After reset all 32 registers hold 00h, host_rdata is 00h, no index is live and every lock is released.
- R2: A window write with win_addr=0 stores an index. A following window write with win_addr=1 stores host_wdata into the register at that index, if the index is in A0h..BFh. A later index write plus data read returns the stored value.
- R3: A data access consumes the live index. A second data write without a new index write changes no register. A second data read without a new index write returns 00h.
- R4: A data access made before any index write since reset is ignored: a write stores nothing and a read returns 00h.
- R5: An index below A0h or above BFh selects no register. A data write with such an index changes no register (A0h and BFh included). A data read with such an index returns 00h. The index is consumed as usual.
- R6: A data-port read updates host_rdata on the clock edge that samples the read strobe. host_rdata holds its value in every other cycle, including cycles with index writes.
- R7: grp_we[g] = host_wr AND ext_hit[g] AND NOT lock[g], combinationally, with this group order and lock bit for g = 0..6:
  - 0: palette, B8h bit 0
  - 1: overscan, B8h bit 1
  - 2: misc output, B8h bit 3
  - 3: hsync polarity, B8h bit 4
  - 4: vsync polarity, B8h bit 5
  - 5: cursor start/end, B4h bit 4
  - 6: vertical timing, B4h bit 3
- R8: vclk_div equals register B8h bits 7:6. The codes 0, 1, 2 and 3 mean divide by 1, 2, 3 and 4.
- R9: clk_code is, MSB to LSB: register BEh bit 4, register B9h bit 1, misc_clk_bits[1], misc_clk_bits[0].
- R10: An index write while an index is live replaces it, and the next data access uses the newer index.
- R11: Cycles with win_hit low neither store an index, nor access a register, nor consume a live index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| win_hit | input | 1 | Current bus cycle targets the register window |
| win_addr | input | 1 | Window address: 0 index port, 1 data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered data-port read value |
| ext_hit | input | 7 | Per-group address match for external register groups |
| misc_clk_bits | input | 2 | Clock select bits 3:2 of the external misc output register |
| grp_we | output | 7 | Lock-gated write enables for the external groups |
| vclk_div | output | 2 | Video clock divider select |
| clk_code | output | 4 | Composite clock select code |

## Verification
A data write lands on the rising edge that samples it, so vclk_div and clk_code show the new value one edge after the write strobe is presented. A data read appears on host_rdata after that same edge. The bench drives strobes on the falling edge, waits through the next rising edge, and samples at the following falling edge, one edge after every stimulus. grp_we depends only on inputs and stored locks, so the bench checks it 1 ns after changing host_wr or ext_hit, within the same cycle, with no clock edge between.

// File: rtl/xrp_pkg.sv
package xrp_pkg;
    localparam int DATA_W   = 8;
    localparam int XREG_LO  = 'hA0;
    localparam int XREG_CNT = 32;
    localparam int SEL_W    = $clog2(XREG_CNT);
    localparam int NGRP     = 7;
    localparam int CKS_W    = 4;
    localparam int DIV_W    = 2;

    // lock source for each external group (register index, bit)
    localparam int GRP_LOCK_REG [NGRP] = '{'hB8, 'hB8, 'hB8, 'hB8, 'hB8, 'hB4, 'hB4};
    localparam int GRP_LOCK_BIT [NGRP] = '{0, 1, 3, 4, 5, 4, 3};

    localparam int DIV_REG    = 'hB8;
    localparam int DIV_LSB    = 6;
    localparam int CKS_HI_REG = 'hBE;
    localparam int CKS_HI_BIT = 4;
    localparam int CKS_MD_REG = 'hB9;
    localparam int CKS_MD_BIT = 1;

    typedef enum logic {XS_IDLE = 1'b0, XS_ARMED = 1'b1} xs_t;
endpackage

// File: rtl/xrp_seq.sv
module xrp_seq
    import xrp_pkg::*;
#(
    parameter int LO  = XREG_LO,
    parameter int CNT = XREG_CNT,
    parameter int SW  = SEL_W,
    parameter int DW  = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_hit,
    input  logic          win_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [SW-1:0] sel,
    output logic          do_wr,
    output logic          do_rd,
    output logic          rd_evt,
    output logic          idx_live
);
    xs_t           st_q, st_d;
    logic [DW-1:0] idx_q;
    logic          idx_wr, dat_acc, in_rng;

    assign idx_wr  = win_hit & host_wr & ~win_addr;
    assign dat_acc = win_hit & win_addr & (host_wr | host_rd);
    assign in_rng  = (int'(idx_q) >= LO) && (int'(idx_q) < LO + CNT);
    assign sel     = SW'(int'(idx_q) - LO);

    // state register and index latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= XS_IDLE;
            idx_q <= '0;
        end else begin
            st_q <= st_d;
            if (idx_wr) idx_q <= host_wdata;
        end
    end

    // next state and outputs
    always_comb begin
        st_d   = st_q;
        do_wr  = 1'b0;
        do_rd  = 1'b0;
        rd_evt = win_hit & win_addr & host_rd;
        unique case (st_q)
            XS_IDLE: begin
                if (idx_wr) st_d = XS_ARMED;          // T_ARM
                // data access here: T_IGNORE
            end
            XS_ARMED: begin
                if (idx_wr) begin
                    st_d = XS_ARMED;                  // T_REARM
                end else if (dat_acc) begin
                    st_d  = XS_IDLE;                  // T_CONSUME
                    do_wr = host_wr & in_rng;
                    do_rd = host_rd & in_rng;
                end
            end
            default: st_d = XS_IDLE;
        endcase
    end

    assign idx_live = (st_q == XS_ARMED);
endmodule

// File: rtl/xrp_regfile.sv
module xrp_regfile
    import xrp_pkg::*;
#(
    parameter int CNT = XREG_CNT,
    parameter int SW  = SEL_W,
    parameter int DW  = DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SW-1:0]           sel,
    input  logic                    do_wr,
    input  logic                    do_rd,
    input  logic                    rd_evt,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic [CNT-1:0][DW-1:0]  regs
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (do_wr) begin
            regs[sel] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_evt) begin
            rdata <= do_rd ? regs[sel] : '0;
        end
    end
endmodule

// File: rtl/xrp_lockgate.sv
module xrp_lockgate
    import xrp_pkg::*;
#(
    parameter int NG = NGRP
) (
    input  logic          host_wr,
    input  logic [NG-1:0] ext_hit,
    input  logic [NG-1:0] lock,
    output logic [NG-1:0] grp_we
);
    for (genvar g = 0; g < NG; g++) begin : g_gate
        assign grp_we[g] = host_wr & ext_hit[g] & ~lock[g];
    end
endmodule

// File: rtl/xreg_port.sv
module xreg_port
    import xrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              win_hit,
    input  logic              win_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [NGRP-1:0]   ext_hit,
    input  logic [1:0]        misc_clk_bits,
    output logic [NGRP-1:0]   grp_we,
    output logic [DIV_W-1:0]  vclk_div,
    output logic [CKS_W-1:0]  clk_code
);
    logic [SEL_W-1:0]                  sel;
    logic                              do_wr, do_rd, rd_evt, idx_live;
    logic [XREG_CNT-1:0][DATA_W-1:0]   regs;
    logic [NGRP-1:0]                   lock;

    xrp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .win_hit(win_hit), .win_addr(win_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .sel(sel), .do_wr(do_wr), .do_rd(do_rd), .rd_evt(rd_evt),
        .idx_live(idx_live)
    );

    xrp_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .sel(sel), .do_wr(do_wr), .do_rd(do_rd),
        .rd_evt(rd_evt), .wdata(host_wdata), .rdata(host_rdata), .regs(regs)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_lock
        assign lock[g] = regs[GRP_LOCK_REG[g] - XREG_LO][GRP_LOCK_BIT[g]];
    end

    xrp_lockgate u_gate (
        .host_wr(host_wr), .ext_hit(ext_hit), .lock(lock), .grp_we(grp_we)
    );

    assign vclk_div = regs[DIV_REG - XREG_LO][DIV_LSB +: DIV_W];
    assign clk_code = {regs[CKS_HI_REG - XREG_LO][CKS_HI_BIT],
                       regs[CKS_MD_REG - XREG_LO][CKS_MD_BIT],
                       misc_clk_bits};
endmodule

// File: rtl/xrp_chk.sv
module xrp_chk
    import xrp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic              win_hit,
    input logic              win_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic [NGRP-1:0]   ext_hit,
    input logic [NGRP-1:0]   grp_we,
    input logic [DIV_W-1:0]  vclk_div,
    input logic              armed
);
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && host_wr && !win_addr) |=> armed);

    p_consume_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && win_hit && win_addr && (host_wr || host_rd)) |=> !armed);

    p_stale_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && win_hit && win_addr && host_rd) |=> (host_rdata == '0));

    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_hit && win_addr && host_rd) |=> $stable(host_rdata));

    p_we_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_we & ~(ext_hit & {NGRP{host_wr}})) == '0);

    p_div_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && win_hit && win_addr && host_wr) |=> $stable(vclk_div));

    p_nowin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |=> $stable(armed));
endmodule

bind xreg_port xrp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .win_hit(win_hit), .win_addr(win_addr), .host_rdata(host_rdata),
    .ext_hit(ext_hit), .grp_we(grp_we), .vclk_div(vclk_div), .armed(idx_live)
);

// File: tb/xreg_port_tb.sv
module xreg_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, win_hit = 1'b0, win_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [6:0] ext_hit = '0;
    logic [1:0] misc_clk_bits = '0;
    logic [6:0] grp_we;
    logic [1:0] vclk_div;
    logic [3:0] clk_code;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xreg_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .win_hit(win_hit), .win_addr(win_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ext_hit(ext_hit), .misc_clk_bits(misc_clk_bits),
        .grp_we(grp_we), .vclk_div(vclk_div), .clk_code(clk_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idx_w(input logic [7:0] v);
        win_hit = 1; win_addr = 0; host_wr = 1; host_wdata = v;
        cyc();
        host_wr = 0; win_hit = 0;
    endtask

    task automatic dat_w(input logic [7:0] v);
        win_hit = 1; win_addr = 1; host_wr = 1; host_wdata = v;
        cyc();
        host_wr = 0; win_hit = 0;
    endtask

    task automatic dat_r(output logic [7:0] v);
        win_hit = 1; win_addr = 1; host_rd = 1;
        cyc();
        host_rd = 0; win_hit = 0;
        v = host_rdata;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
        idx_w(idx); dat_w(v);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
        idx_w(idx); dat_r(v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk(host_rdata == 8'h00, "R1 rdata after reset", host_rdata, 0);
        chk(vclk_div == 2'd0, "R1 divider after reset", vclk_div, 0);
        chk(clk_code == 4'd0, "R1 clock code after reset", clk_code, 0);
        host_wr = 1; ext_hit = 7'h7F; #1;
        chk(grp_we == 7'h7F, "R1 no locks after reset", grp_we, 'h7F);
        host_wr = 0; ext_hit = 0;
        rd_reg(8'hB8, v);
        chk(v == 8'h00, "R1 register B8 reset value", v, 0);
    endtask

    task automatic t_noidx();
        logic [7:0] v;
        // restart with a fresh reset so no index has been written
        rst_n = 0; cyc(); rst_n = 1;
        dat_w(8'h77);
        dat_r(v);
        chk(v == 8'h00, "R4 read with no index", v, 0);
        rd_reg(8'hA0, v);
        chk(v == 8'h00, "R4 write with no index ignored", v, 0);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        wr_reg(8'hA0, 8'h5A); wr_reg(8'hA7, 8'hC3); wr_reg(8'hBF, 8'h81);
        rd_reg(8'hA0, v); chk(v == 8'h5A, "R2 readback A0", v, 'h5A);
        rd_reg(8'hA7, v); chk(v == 8'hC3, "R2 readback A7", v, 'hC3);
        rd_reg(8'hBF, v); chk(v == 8'h81, "R2 readback BF", v, 'h81);
    endtask

    task automatic t_consume();
        logic [7:0] v;
        idx_w(8'hA5); dat_w(8'h11); dat_w(8'h22);
        dat_r(v); chk(v == 8'h00, "R3 read after consumed index", v, 0);
        rd_reg(8'hA5, v); chk(v == 8'h11, "R3 second write ignored", v, 'h11);
    endtask

    task automatic t_range();
        logic [7:0] v;
        wr_reg(8'h9F, 8'h55); wr_reg(8'hC0, 8'h66); wr_reg(8'h00, 8'h44);
        rd_reg(8'h9F, v); chk(v == 8'h00, "R5 read index 9F", v, 0);
        rd_reg(8'hC0, v); chk(v == 8'h00, "R5 read index C0", v, 0);
        rd_reg(8'hA0, v); chk(v == 8'h5A, "R5 A0 untouched", v, 'h5A);
        rd_reg(8'hBF, v); chk(v == 8'h81, "R5 BF untouched", v, 'h81);
        idx_w(8'hC1); dat_w(8'h12);
        dat_r(v); chk(v == 8'h00, "R5 out-of-range index consumed", v, 0);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        rd_reg(8'hA7, v);
        chk(host_rdata == 8'hC3, "R6 rdata one edge after read", host_rdata, 'hC3);
        idx_w(8'hA0); cyc(); cyc();
        chk(host_rdata == 8'hC3, "R6 rdata held", host_rdata, 'hC3);
        dat_w(8'h5A);
        chk(host_rdata == 8'hC3, "R6 rdata held over data write", host_rdata, 'hC3);
    endtask

    task automatic t_rearm();
        logic [7:0] v;
        idx_w(8'hA1); idx_w(8'hA2); dat_w(8'h99);
        rd_reg(8'hA2, v); chk(v == 8'h99, "R10 newer index used", v, 'h99);
        rd_reg(8'hA1, v); chk(v == 8'h00, "R10 older index unused", v, 0);
    endtask

    task automatic t_nowin();
        logic [7:0] v;
        idx_w(8'hA4);
        host_wr = 1; win_addr = 1; host_wdata = 8'hEE; cyc();
        win_addr = 0; host_wdata = 8'hA6; cyc();
        host_wr = 0;
        dat_r(v); chk(v == 8'h00, "R11 A4 kept and unwritten", v, 0);
        rd_reg(8'hA6, v); chk(v == 8'h00, "R11 A6 unwritten", v, 0);
        idx_w(8'hA4); dat_w(8'h3C);
        rd_reg(8'hA4, v); chk(v == 8'h3C, "R11 window works again", v, 'h3C);
    endtask

    task automatic t_locks();
        wr_reg(8'hB8, 8'h01);
        host_wr = 1; ext_hit = 7'h7F; #1;
        chk(grp_we == 7'b1111110, "R7 palette lock", grp_we, 'h7E);
        host_wr = 0;
        wr_reg(8'hB8, 8'h3B); wr_reg(8'hB4, 8'h10);
        host_wr = 1; ext_hit = 7'h7F; #1;
        chk(grp_we == 7'b1000000, "R7 B8 locks and cursor lock", grp_we, 'h40);
        host_wr = 0;
        wr_reg(8'hB4, 8'h18);
        host_wr = 1; ext_hit = 7'h7F; #1;
        chk(grp_we == 7'b0000000, "R7 all locked", grp_we, 0);
        host_wr = 0;
        wr_reg(8'hB8, 8'h04); wr_reg(8'hB4, 8'h08);
        host_wr = 1; ext_hit = 7'b0100101; #1;
        chk(grp_we == 7'b0100101, "R7 partial hit, B8 bit 2 no lock", grp_we, 'h25);
        host_wr = 0; #1;
        chk(grp_we == 7'b0, "R7 no strobe", grp_we, 0);
        ext_hit = 0;
    endtask

    task automatic t_div();
        for (int d = 0; d < 4; d++) begin
            wr_reg(8'hB8, 8'((d << 6) | 8'h05));
            chk(vclk_div == 2'(d), "R8 divider select", vclk_div, d);
        end
    endtask

    task automatic t_clk();
        wr_reg(8'hBE, 8'h10); wr_reg(8'hB9, 8'h02); misc_clk_bits = 2'b01; #1;
        chk(clk_code == 4'b1101, "R9 clock code 1101", clk_code, 'hD);
        wr_reg(8'hBE, 8'hEF); misc_clk_bits = 2'b10; #1;
        chk(clk_code == 4'b0110, "R9 clock code 0110", clk_code, 'h6);
        wr_reg(8'hB9, 8'hFD); #1;
        chk(clk_code == 4'b0010, "R9 clock code 0010", clk_code, 'h2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        t_reset();
        t_noidx();
        t_basic();
        t_consume();
        t_range();
        t_hold();
        t_rearm();
        t_nowin();
        t_locks();
        t_div();
        t_clk();
        finish_run();
    end
endmodule